// File: doc/BRIEF.md
# Buffered-Update PWM Generator

This block makes a single PWM pulse train from a free-running up-counter. The counter runs from zero to its all-ones value and then wraps. One full count span is one PWM period. The output is high while the counter is below the active compare value and low at all other counts.

Software never writes the active compare value directly. It writes a staging register and then sets an arm flag. At the last count of a period, the block checks the flag. If the flag is set, the staged value moves into the active register and the flag clears itself. The new duty therefore starts cleanly with the first count of the next period. If software clears the flag before the boundary, the pending update is cancelled and the old duty stays in force.

Top module: `pwm_buf_gen`

## Requirements
- R1: The counter advances by one every clock and wraps from 2^CNT_W-1 to 0, so one PWM period lasts 2^CNT_W clocks.
- R2: `pwm_o` is high exactly while the counter is below the active compare value. An active value of 0 keeps the output low for the whole period. An active value of 2^CNT_W-1 keeps it high for all counts but the last.
- R3: A write on `cmp_we_i` changes only the staging register, and the output does not change. The staged value becomes active in the clock where the counter wraps to 0, and only if the flag was 1 during the last count.
- R4: When that load happens, the flag clears in the same edge, and `arm_o` reads 0 afterwards.
- R5: If software writes 0 to the flag (`arm_we_i`=1, `arm_val_i`=0) before the last count, no load happens at that wrap. The active value and the output pattern stay as they were.
- R6: A flag write of either value in the last-count clock, while the flag is 1, does not stop the load. The hardware clear wins, so `arm_o` reads 0 after that edge.
- R7: A flag write of 1 in the last-count clock, while the flag is 0, loads nothing at that wrap. `arm_o` reads 1 afterwards, and the load happens at the next wrap.
- R8: While the flag is armed, the staging register may be rewritten any number of times. Only the value it holds during the last count is loaded.
- R9: While `rst_ni` is low, the counter, flag, staging and active registers all clear asynchronously, so `pwm_o` and `arm_o` are 0.
- R10: A flag write at any count other than the last sets `arm_o` to `arm_val_i` from the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmp_we_i | input | 1 | Write strobe for the staging compare register |
| cmp_data_i | input | CNT_W | Compare value to stage |
| arm_we_i | input | 1 | Write strobe for the arm flag |
| arm_val_i | input | 1 | Value written to the arm flag |
| arm_o | output | 1 | Arm flag readback |
| pwm_o | output | 1 | PWM pulse output |

## Verification
The bench builds the block with CNT_W=4, so one period is only 16 clocks. At that size every compare value from 0 to 15 can be loaded and its duty measured over a whole period. Every flag race at the wrap can then be placed exactly on the last count: cancel, write 0 or 1 while armed, and write 1 while idle. A reference model of the counter, staging register and flag predicts `pwm_o` and `arm_o` on every clock.

// File: rtl/pwm_buf_pkg.sv
package pwm_buf_pkg;
  localparam int unsigned DEF_CNT_W = 10;

  typedef struct packed {
    logic we;
    logic val;
  } arm_wr_t;
endpackage

// File: rtl/pwm_cnt.sv
module pwm_cnt #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = (cnt_q == CNT_MAX);

  p_wrap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (cnt_o == '0));
  p_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap_o |=> (cnt_o == $past(cnt_o) + 1'b1));
endmodule

// File: rtl/pwm_cmp_buf.sv
module pwm_cmp_buf
  import pwm_buf_pkg::*;
#(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wrap_i,
  input  logic             cmp_we_i,
  input  logic [CNT_W-1:0] cmp_data_i,
  input  arm_wr_t          arm_wr_i,
  output logic             arm_o,
  output logic [CNT_W-1:0] cmp_act_o
);
  logic [CNT_W-1:0] hold_q;
  logic [CNT_W-1:0] act_q;
  logic             arm_q;
  logic             load;

  // load only when armed at the last count; hw clear beats sw write
  assign load = wrap_i & arm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       hold_q <= '0;
    else if (cmp_we_i) hold_q <= cmp_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   act_q <= '0;
    else if (load) act_q <= hold_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          arm_q <= 1'b0;
    else if (load)        arm_q <= 1'b0;
    else if (arm_wr_i.we) arm_q <= arm_wr_i.val;
  end

  assign arm_o     = arm_q;
  assign cmp_act_o = act_q;

  p_autoclr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_i && arm_o) |=> !arm_o);
  p_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_i && arm_o) |=> (cmp_act_o == $past(hold_q)));
  p_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wrap_i && arm_o) |=> $stable(cmp_act_o));
  p_swwr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wrap_i && arm_wr_i.we) |=> (arm_o == $past(arm_wr_i.val)));
  p_lateset_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_i && !arm_o && arm_wr_i.we && arm_wr_i.val) |=> arm_o);
endmodule

// File: rtl/pwm_out.sv
module pwm_out #(
  parameter int unsigned CNT_W = 10
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic             pwm_o
);
  assign pwm_o = (cnt_i < cmp_i);
endmodule

// File: rtl/pwm_buf_gen.sv
module pwm_buf_gen
  import pwm_buf_pkg::*;
#(
  parameter int unsigned CNT_W = DEF_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmp_we_i,
  input  logic [CNT_W-1:0] cmp_data_i,
  input  logic             arm_we_i,
  input  logic             arm_val_i,
  output logic             arm_o,
  output logic             pwm_o
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cmp_act;
  logic             wrap;
  arm_wr_t          arm_wr;

  assign arm_wr = '{we: arm_we_i, val: arm_val_i};

  pwm_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt_o  (cnt),
    .wrap_o (wrap)
  );

  pwm_cmp_buf #(.CNT_W(CNT_W)) u_buf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wrap_i     (wrap),
    .cmp_we_i   (cmp_we_i),
    .cmp_data_i (cmp_data_i),
    .arm_wr_i   (arm_wr),
    .arm_o      (arm_o),
    .cmp_act_o  (cmp_act)
  );

  pwm_out #(.CNT_W(CNT_W)) u_out (
    .cnt_i (cnt),
    .cmp_i (cmp_act),
    .pwm_o (pwm_o)
  );

  p_low_last_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |-> !pwm_o);
  p_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cnt == '0) && (cmp_act != '0)) |-> pwm_o);
endmodule

// File: tb/pwm_buf_gen_tb.sv
`timescale 1ns/1ps
module pwm_buf_gen_tb;
  localparam int unsigned W = 4;
  localparam int unsigned PER = 1 << W;
  localparam int unsigned MAXC = PER - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmp_we = 1'b0;
  logic [W-1:0] cmp_data = '0;
  logic         arm_we = 1'b0;
  logic         arm_val = 1'b0;
  logic         arm;
  logic         pwm;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int unsigned m_cnt, m_act, m_hold;
  bit          m_arm;

  always #2 clk = ~clk;

  pwm_buf_gen #(.CNT_W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmp_we_i(cmp_we), .cmp_data_i(cmp_data),
    .arm_we_i(arm_we), .arm_val_i(arm_val), .arm_o(arm), .pwm_o(pwm)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at t=%0t", tag, act, exp, $time);
    end
  endtask

  // one clock: drive, edge, model update, sample
  task automatic step(input bit we, input int d, input bit awe, input bit aval, input string tag);
    bit pe;
    cmp_we = we; cmp_data = W'(d); arm_we = awe; arm_val = aval;
    @(posedge clk);
    pe = (m_cnt == MAXC);
    if (pe && m_arm) begin m_act = m_hold; m_arm = 0; end
    else if (awe) m_arm = aval;
    if (we) m_hold = d;
    m_cnt = pe ? 0 : m_cnt + 1;
    #1;
    cmp_we = 0; arm_we = 0; arm_val = 0;
    chk({tag, " pwm"}, pwm, (m_cnt < m_act) ? 1 : 0);
    chk({tag, " arm"}, arm, m_arm);
  endtask

  task automatic to_last(input string tag);
    while (m_cnt != MAXC) step(0, 0, 0, 0, tag);
  endtask

  // wrap edge plus a full period; returns high cycles
  task automatic measure(input string tag, output int hi);
    hi = 0;
    for (int i = 0; i < PER; i++) begin
      step(0, 0, 0, 0, tag);
      hi += pwm;
    end
  endtask

  initial begin
    int hi;
    m_cnt = 0; m_act = 0; m_hold = 0; m_arm = 0;
    #1;
    chk("R9 reset pwm", pwm, 0);
    chk("R9 reset arm", arm, 0);
    #10;
    @(negedge clk); rst_n = 1'b1;

    // R1/R2/R3/R4: sweep all compare values
    for (int v = 0; v < PER; v++) begin
      step(1, v, 1, 1, "R10 arm");
      to_last("R3 wait");
      measure("R2 sweep", hi);
      chk("R2 duty", hi, v);
      chk("R4 autoclear", arm, 0);
    end

    // R3: staged write without arm changes nothing
    step(1, 3, 0, 0, "R3 stage");
    to_last("R3 wait");
    measure("R3 noarm", hi);
    chk("R3 noarm duty", hi, MAXC);

    // R5: cancel before wrap
    step(1, 6, 1, 1, "R5 arm");
    step(0, 0, 1, 0, "R5 cancel");
    to_last("R5 wait");
    measure("R5 keep", hi);
    chk("R5 duty", hi, MAXC);

    // R6: write 0 in last clock while armed
    step(1, 9, 1, 1, "R6 arm");
    to_last("R6 wait");
    step(0, 0, 1, 0, "R6 race0");
    chk("R6 arm0", arm, 0);
    for (int i = 1; i < PER; i++) step(0, 0, 0, 0, "R6 run");
    measure("R6 load0", hi);
    chk("R6 duty0", hi, 9);

    // R6: write 1 in last clock while armed
    step(1, 2, 1, 1, "R6 arm");
    to_last("R6 wait");
    step(0, 0, 1, 1, "R6 race1");
    chk("R6 arm1", arm, 0);
    for (int i = 1; i < PER; i++) step(0, 0, 0, 0, "R6 run");
    measure("R6 load1", hi);
    chk("R6 duty1", hi, 2);

    // R7: late arm while idle
    step(1, 12, 0, 0, "R7 stage");
    to_last("R7 wait");
    step(0, 0, 1, 1, "R7 late");
    chk("R7 armed", arm, 1);
    for (int i = 1; i < PER; i++) step(0, 0, 0, 0, "R7 run");
    chk("R7 old duty pending", arm, 1);
    measure("R7 next", hi);
    chk("R7 duty", hi, 12);
    chk("R7 cleared", arm, 0);

    // R8: rewrite staging while armed
    step(1, 1, 1, 1, "R8 arm");
    step(1, 7, 0, 0, "R8 rw");
    step(1, 4, 0, 0, "R8 rw");
    to_last("R8 wait");
    step(1, 11, 0, 0, "R8 lastrw");
    for (int i = 1; i < PER; i++) step(0, 0, 0, 0, "R8 run");
    measure("R8 final", hi);
    chk("R8 duty", hi, 4);

    // R9: async reset mid-run
    step(1, 8, 1, 1, "R9 pre");
    #1 rst_n = 1'b0;
    #1;
    chk("R9 async pwm", pwm, 0);
    chk("R9 async arm", arm, 0);
    m_cnt = 0; m_act = 0; m_hold = 0; m_arm = 0;
    @(negedge clk); rst_n = 1'b1;
    measure("R9 after", hi);
    chk("R9 duty", hi, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule